// File: doc/BRIEF.md
# Execution Mode Summary Decoder

This block condenses the processor's architectural control state into one registered summary word that an instruction decoder can read without looking at the individual control registers. The inputs are single control bits: the long-mode-active flag, the protection-enable and paging-enable bits of the primary control register, the virtual-8086 bit of the flags register, the long bit, default-size bit and privilege field of the code-segment attributes, and the default-size bit of the stack-segment attributes. The summary word gives the main mode, the submode, the current privilege level, paging and protection flags, and size codes for default and alternate operand size, default and alternate address size, and stack size.

The summary changes only on a recompute. A recompute is requested either by the `refresh_i` strobe or by a register-file write whose index equals the summary's own index `SELF_IDX`. No write data is routed to the block, so the contents of such a write can never reach the summary. The recompute reads the current source bits. On the same edge `dec_update_o` rises for one cycle to tell the decoder that a new summary is present. All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `exec_mode_decoder`

## Requirements
- R1: When `lma_i` is 1 after a recompute, the main mode is 1 (long). The submode is 4 (64-bit) if `cs_long_i` is 1, otherwise 3 (compatibility).
- R2: When `lma_i` is 0 after a recompute, the main mode is 0 (legacy). The submode is 0 (real) if `cr0_pe_i` is 0, 1 (virtual-8086) if `cr0_pe_i` and `flags_vm_i` are both 1, and 2 (protected) if `cr0_pe_i` is 1 and `flags_vm_i` is 0.
- R3: A recompute copies `cs_dpl_i` into the privilege field, `cr0_pg_i` into the paging flag and `cr0_pe_i` into the protection flag.
- R4: Operand size codes (default/alternate) are 2/1 in 64-bit submode or when `cs_dsz_i` is 1, and 1/2 otherwise. Size codes mean 1 = 16-bit, 2 = 32-bit, 3 = 64-bit.
- R5: Address size codes (default/alternate) are 3/2 in 64-bit submode, 2/1 otherwise when `cs_dsz_i` is 1, and 1/2 in the remaining cases.
- R6: The stack size code is 3 in 64-bit submode, 2 otherwise when `ss_dsz_i` is 1, and 1 in the remaining cases.
- R7: When `refresh_i` is high at a rising edge, the summary takes the new value at that edge. `dec_update_o` is 1 during the following cycle only.
- R8: A write with `wr_en_i` = 1 and `wr_idx_i` = `SELF_IDX` triggers the same recompute and pulse as R7. The block has no write-data input.
- R9: With no recompute at an edge, which includes writes to any other index, the summary holds its value and `dec_update_o` is 0, even when the source bits change.
- R10: While `rst_ni` is low, `summary_o` is all zeros and `dec_update_o` is 0.
- R11: `summary_o` is packed as: [17] main mode, [16:14] submode, [13:12] privilege, [11] paging, [10] protection, [9:8] default operand, [7:6] alternate operand, [5:4] default address, [3:2] alternate address, [1:0] stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lma_i | input | 1 | Long mode active |
| cr0_pe_i | input | 1 | Protection enable |
| cr0_pg_i | input | 1 | Paging enable |
| flags_vm_i | input | 1 | Virtual-8086 flag |
| cs_long_i | input | 1 | Code segment long bit |
| cs_dsz_i | input | 1 | Code segment default-size bit |
| cs_dpl_i | input | DPL_W | Code segment privilege level |
| ss_dsz_i | input | 1 | Stack segment default-size bit |
| refresh_i | input | 1 | Recompute strobe |
| wr_en_i | input | 1 | Register-file write strobe |
| wr_idx_i | input | IDX_W | Register-file write index |
| summary_o | output | 18 | Registered summary word |
| dec_update_o | output | 1 | One-cycle decoder update pulse |

## Verification
The bench builds the block with its default parameters: a 6-bit index and `SELF_IDX` = 33. Write indices are drawn randomly from 30 to 36, so self-index writes land among writes to the neighbouring indices. That exposes an index decode that is off by one or compares too few bits. All eight source bits are drawn randomly on every cycle, so every submode appears, as do the 64-bit overrides of the size codes and the combinations where the default-size bits conflict. The cycles with no strobe check that the summary holds while the inputs keep moving.

// File: rtl/exec_mode_pkg.sv
package exec_mode_pkg;

  typedef enum logic {
    MAIN_LEGACY = 1'b0,
    MAIN_LONG   = 1'b1
  } main_mode_e;

  typedef enum logic [2:0] {
    SUB_REAL   = 3'd0,
    SUB_V86    = 3'd1,
    SUB_PROT   = 3'd2,
    SUB_COMPAT = 3'd3,
    SUB_64     = 3'd4
  } sub_mode_e;

  localparam int CODE_W = 2;
  localparam logic [CODE_W-1:0] SZ_16 = 2'd1;
  localparam logic [CODE_W-1:0] SZ_32 = 2'd2;
  localparam logic [CODE_W-1:0] SZ_64 = 2'd3;

  typedef struct packed {
    main_mode_e        main;
    sub_mode_e         sub;
    logic [1:0]        cpl;
    logic              paging;
    logic              prot;
    logic [CODE_W-1:0] op_def;
    logic [CODE_W-1:0] op_alt;
    logic [CODE_W-1:0] ad_def;
    logic [CODE_W-1:0] ad_alt;
    logic [CODE_W-1:0] stk;
  } exec_summary_t;

  localparam int SUMMARY_W = $bits(exec_summary_t);

endpackage

// File: rtl/exec_mode_classify.sv
module exec_mode_classify
  import exec_mode_pkg::*;
(
  input  logic       lma_i,
  input  logic       pe_i,
  input  logic       vm_i,
  input  logic       cs_long_i,
  output main_mode_e main_o,
  output sub_mode_e  sub_o
);

  always_comb begin
    if (lma_i) begin
      main_o = MAIN_LONG;
      sub_o  = cs_long_i ? SUB_64 : SUB_COMPAT;
    end else begin
      main_o = MAIN_LEGACY;
      if (!pe_i)     sub_o = SUB_REAL;
      else if (vm_i) sub_o = SUB_V86;
      else           sub_o = SUB_PROT;
    end
  end

endmodule

// File: rtl/exec_size_select.sv
module exec_size_select
  import exec_mode_pkg::*;
(
  input  logic              is64_i,
  input  logic              cs_dsz_i,
  input  logic              ss_dsz_i,
  output logic [CODE_W-1:0] op_def_o,
  output logic [CODE_W-1:0] op_alt_o,
  output logic [CODE_W-1:0] ad_def_o,
  output logic [CODE_W-1:0] ad_alt_o,
  output logic [CODE_W-1:0] stk_o
);

  always_comb begin
    // operand: 64-bit code still defaults to 32-bit operands
    if (is64_i || cs_dsz_i) begin
      op_def_o = SZ_32;
      op_alt_o = SZ_16;
    end else begin
      op_def_o = SZ_16;
      op_alt_o = SZ_32;
    end

    if (is64_i) begin
      ad_def_o = SZ_64;
      ad_alt_o = SZ_32;
    end else if (cs_dsz_i) begin
      ad_def_o = SZ_32;
      ad_alt_o = SZ_16;
    end else begin
      ad_def_o = SZ_16;
      ad_alt_o = SZ_32;
    end

    if (is64_i)        stk_o = SZ_64;
    else if (ss_dsz_i) stk_o = SZ_32;
    else               stk_o = SZ_16;
  end

endmodule

// File: rtl/exec_mode_decoder.sv
module exec_mode_decoder
  import exec_mode_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int SELF_IDX = 33,
  parameter int DPL_W    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 lma_i,
  input  logic                 cr0_pe_i,
  input  logic                 cr0_pg_i,
  input  logic                 flags_vm_i,
  input  logic                 cs_long_i,
  input  logic                 cs_dsz_i,
  input  logic [DPL_W-1:0]     cs_dpl_i,
  input  logic                 ss_dsz_i,
  input  logic                 refresh_i,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  output logic [SUMMARY_W-1:0] summary_o,
  output logic                 dec_update_o
);

  localparam logic [IDX_W-1:0] SELF_IDX_L = IDX_W'(SELF_IDX);

  main_mode_e        main_n;
  sub_mode_e         sub_n;
  logic [CODE_W-1:0] op_def_n, op_alt_n, ad_def_n, ad_alt_n, stk_n;
  exec_summary_t     next_sum, sum_q;
  logic              recompute;
  logic              upd_q;

  exec_mode_classify u_classify (
    .lma_i     (lma_i),
    .pe_i      (cr0_pe_i),
    .vm_i      (flags_vm_i),
    .cs_long_i (cs_long_i),
    .main_o    (main_n),
    .sub_o     (sub_n)
  );

  exec_size_select u_sizes (
    .is64_i   (sub_n == SUB_64),
    .cs_dsz_i (cs_dsz_i),
    .ss_dsz_i (ss_dsz_i),
    .op_def_o (op_def_n),
    .op_alt_o (op_alt_n),
    .ad_def_o (ad_def_n),
    .ad_alt_o (ad_alt_n),
    .stk_o    (stk_n)
  );

  always_comb begin
    next_sum        = '0;
    next_sum.main   = main_n;
    next_sum.sub    = sub_n;
    next_sum.cpl    = 2'(cs_dpl_i);
    next_sum.paging = cr0_pg_i;
    next_sum.prot   = cr0_pe_i;
    next_sum.op_def = op_def_n;
    next_sum.op_alt = op_alt_n;
    next_sum.ad_def = ad_def_n;
    next_sum.ad_alt = ad_alt_n;
    next_sum.stk    = stk_n;
  end

  assign recompute = refresh_i | (wr_en_i && (wr_idx_i == SELF_IDX_L));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= recompute;
      if (recompute) sum_q <= next_sum;
    end
  end

  assign summary_o    = sum_q;
  assign dec_update_o = upd_q;

endmodule

// File: rtl/exec_mode_decoder_chk.sv
module exec_mode_decoder_chk
  import exec_mode_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int SELF_IDX = 33,
  parameter int DPL_W    = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 lma_i,
  input logic                 cs_long_i,
  input logic [DPL_W-1:0]     cs_dpl_i,
  input logic                 cr0_pg_i,
  input logic                 refresh_i,
  input logic                 wr_en_i,
  input logic [IDX_W-1:0]     wr_idx_i,
  input logic [SUMMARY_W-1:0] summary_o,
  input logic                 dec_update_o
);

  exec_summary_t s;
  assign s = exec_summary_t'(summary_o);

  logic self_wr;
  assign self_wr = wr_en_i && (wr_idx_i == IDX_W'(SELF_IDX));

  // R7
  refresh_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_i |=> dec_update_o);

  // R8
  self_write_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    self_wr |=> dec_update_o);

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(refresh_i || self_wr) |=> ($stable(summary_o) && !dec_update_o));

  // R1
  long_sub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refresh_i && lma_i) |=> (s.main == MAIN_LONG &&
      s.sub == ($past(cs_long_i) ? SUB_64 : SUB_COMPAT)));

  // R2
  legacy_sub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refresh_i && !lma_i) |=> (s.main == MAIN_LEGACY && s.sub <= SUB_PROT));

  // R3
  cpl_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_i |=> (s.cpl == 2'($past(cs_dpl_i)) && s.paging == $past(cr0_pg_i)));

  // R4
  op_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_update_o |-> (s.op_def != s.op_alt && s.op_def != SZ_64));

  // R6
  stack_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_update_o |-> (s.stk != 2'd0 && ((s.sub == SUB_64) == (s.stk == SZ_64))));

  // R10
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (!dec_update_o);
    end
  end

endmodule

bind exec_mode_decoder exec_mode_decoder_chk #(
  .IDX_W(IDX_W), .SELF_IDX(SELF_IDX), .DPL_W(DPL_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lma_i        (lma_i),
  .cs_long_i    (cs_long_i),
  .cs_dpl_i     (cs_dpl_i),
  .cr0_pg_i     (cr0_pg_i),
  .refresh_i    (refresh_i),
  .wr_en_i      (wr_en_i),
  .wr_idx_i     (wr_idx_i),
  .summary_o    (summary_o),
  .dec_update_o (dec_update_o)
);

// File: tb/exec_mode_decoder_tb.sv
module exec_mode_decoder_tb;

  localparam int SELF = 33;

  logic clk = 0;
  logic rst_n = 0;
  logic lma = 0, pe = 0, pg = 0, vm = 0, cl = 0, cdsz = 0, sdsz = 0;
  logic [1:0] dpl = 0;
  logic refresh = 0, wr_en = 0;
  logic [5:0] wr_idx = 0;
  logic [17:0] summary;
  logic dec_upd;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  logic done = 0;

  always #2.5 clk = ~clk;

  exec_mode_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .lma_i(lma), .cr0_pe_i(pe), .cr0_pg_i(pg),
    .flags_vm_i(vm), .cs_long_i(cl), .cs_dsz_i(cdsz), .cs_dpl_i(dpl),
    .ss_dsz_i(sdsz), .refresh_i(refresh), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .summary_o(summary), .dec_update_o(dec_upd)
  );

  // Behavioural reference: integer arithmetic on the requirements.
  function automatic logic [17:0] ref_summary();
    int main, sub, od, oa, ad, aa, st;
    main = lma ? 1 : 0;
    if (lma) sub = cl ? 4 : 3;
    else if (!pe) sub = 0;
    else sub = vm ? 1 : 2;
    if (sub == 4 || cdsz) begin od = 2; oa = 1; end else begin od = 1; oa = 2; end
    if (sub == 4) begin ad = 3; aa = 2; end
    else if (cdsz) begin ad = 2; aa = 1; end
    else begin ad = 1; aa = 2; end
    st = (sub == 4) ? 3 : (sdsz ? 2 : 1);
    return {main[0], sub[2:0], dpl, pg, pe, od[1:0], oa[1:0], ad[1:0], aa[1:0], st[1:0]};
  endfunction

  logic [17:0] exp_sum = '0;
  logic exp_upd = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_sum <= '0;
      exp_upd <= 0;
    end else begin
      exp_upd <= refresh || (wr_en && wr_idx == 6'(SELF));
      if (refresh || (wr_en && wr_idx == 6'(SELF))) exp_sum <= ref_summary();
    end
  end

  task automatic field(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    field("R1/R2/R11 main", int'(summary[17]), int'(exp_sum[17]));
    field("R1/R2/R11 submode", int'(summary[16:14]), int'(exp_sum[16:14]));
    field("R3 cpl", int'(summary[13:12]), int'(exp_sum[13:12]));
    field("R3 paging", int'(summary[11]), int'(exp_sum[11]));
    field("R3 prot", int'(summary[10]), int'(exp_sum[10]));
    field("R4 operand", int'(summary[9:6]), int'(exp_sum[9:6]));
    field("R5 address", int'(summary[5:2]), int'(exp_sum[5:2]));
    field("R6 stack", int'(summary[1:0]), int'(exp_sum[1:0]));
    field("R7/R8/R9 update", int'(dec_upd), int'(exp_upd));
  endtask

  task automatic drive_random();
    {lma, pe, pg, vm, cl, cdsz, sdsz} = 7'($urandom);
    dpl = 2'($urandom);
    refresh = ($urandom_range(0, 9) < 3);
    wr_en = ($urandom_range(0, 9) < 4);
    wr_idx = 6'($urandom_range(30, 36));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // R10: reset state while held in reset, inputs active
    lma = 1; cl = 1; refresh = 1;
    repeat (3) @(negedge clk);
    field("R10 reset summary", int'(summary), 0);
    field("R10 reset update", int'(dec_upd), 0);
    rst_n = 1;
    refresh = 0;
    @(negedge clk);
    compare_all();
    // Directed R8: self-index write with no refresh
    lma = 0; pe = 1; vm = 1; dpl = 2'd3; wr_en = 1; wr_idx = 6'(SELF);
    @(negedge clk);
    compare_all();
    // Directed R9: neighbouring index, inputs change
    lma = 1; cl = 1; wr_idx = 6'(SELF + 1);
    @(negedge clk);
    compare_all();
    wr_en = 0;
    @(negedge clk);
    compare_all();
    for (int i = 0; i < 3000; i++) begin
      drive_random();
      @(negedge clk);
      compare_all();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule